// File: doc/BRIEF.md
# Per-Pixel Colour Source Selector

This block sits in the pixel stream of a framebuffer that keeps three planes for every pixel: an 8-bit palette index, a 32-bit direct-colour word and a 32-bit control word. The three values for one pixel arrive together in a single input beat. For each beat the block reads the top byte of the control word. If that byte holds the direct tag, the pixel's colour is taken from the low 24 bits of the direct-colour word. If it does not, the index is sent to an external palette port and the pixel's colour is the value that comes back. Both kinds of pixel can be mixed freely within one scanline.

Palette storage, memory fetch and display timing belong to other blocks. The palette port is a plain synchronous read: an address is presented with a request strobe, and the colour returns on the next cycle. The direct path is delayed to match, so every pixel has the same latency. The input and output both use valid/ready handshakes. Stalls on the output are absorbed without losing or repeating a pixel.

Scanlines have a fixed stride of 1024 pixels. The block tracks the position of each output beat within that stride and flags the last beat of every line.

Top module: `pix_colour_sel`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0, `pal_req` is 0 and `in_ready` is 1.
- R2: A pixel is direct when bits 31:24 of `in_ctrl` equal 8'h03. Bits 23:0 of `in_ctrl` take no part in that decision. Every other top-byte value selects the palette.
- R3: For a direct pixel, `out_rgb` equals `in_direct[23:0]`, with bits 23:16 as red in `out_rgb[23:16]`, bits 15:8 as green in `out_rgb[15:8]` and bits 7:0 as blue in `out_rgb[7:0]`. `in_direct[31:24]` and `in_index` have no effect on the result.
- R4: For a palette pixel, `pal_req` is 1 and `pal_addr` equals `in_index` in the cycle the beat is accepted. The pixel's `out_rgb` is the `pal_rgb` value present in the following cycle, and `in_direct` has no effect on the result.
- R5: `pal_req` is 1 only in a cycle where a palette pixel is accepted. It stays 0 for direct pixels and in idle cycles.
- R6: Every accepted input beat produces exactly one output beat, and output beats come out in input order.
- R7: With `out_ready` held at 1, a beat accepted at clock edge k is presented on the output after edge k+1, and `in_ready` is 1 in every cycle where `out_ready` is 1, which gives one pixel per cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and keeps `out_rgb` unchanged.
- R9: A palette colour is captured in the cycle it returns. A stall that lasts past that cycle does not let later `pal_rgb` values change the pixel.
- R10: `out_eol` is 1 on output beat number 1023, 2047 and so on, counting beats from 0 after reset, which is the last beat of each 1024-pixel line. It is 0 on every other beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An input pixel beat is present |
| in_ready | output | 1 | The block accepts the beat this cycle |
| in_index | input | 8 | Palette index plane value |
| in_direct | input | 32 | Direct-colour plane word |
| in_ctrl | input | 32 | Control plane word; top byte is the source tag |
| pal_req | output | 1 | Palette read strobe |
| pal_addr | output | 8 | Palette read address |
| pal_rgb | input | 24 | Palette read data, valid one cycle after `pal_req` |
| out_valid | output | 1 | An output colour is present |
| out_ready | input | 1 | The consumer takes the colour this cycle |
| out_rgb | output | 24 | Resolved colour, red in the top byte |
| out_eol | output | 1 | The current output beat is the last of a line |

## Verification
Palette request and address are due in the same cycle as the input acceptance. The palette colour is due one cycle later. An unstalled pixel reaches the output port two edges after it is accepted. The bench drives inputs just after a rising edge and reads every port at the falling edge, so each value is sampled in the cycle it belongs to. A queue of expected colours, filled at acceptance and drained at each output handshake, keeps the check independent of stall length. The palette model returns random data in every cycle except the one right after a request, so a pixel that picks up its colour late is caught. A directed single-pixel case checks the exact two-edge timing, and a per-beat counter in the bench predicts each end-of-line flag.

// File: rtl/pix_sel_pkg.sv
package pix_sel_pkg;

    localparam int IDX_W   = 8;
    localparam int WORD_W  = 32;
    localparam int CHAN_W  = 8;
    localparam int RGB_W   = 3 * CHAN_W;
    localparam int TAG_W   = 8;
    localparam logic [TAG_W-1:0] TAG_DIRECT = 8'h03;

    typedef struct packed {
        logic [CHAN_W-1:0] r;
        logic [CHAN_W-1:0] g;
        logic [CHAN_W-1:0] b;
    } rgb_t;

    typedef enum logic {
        SRC_PALETTE = 1'b0,
        SRC_DIRECT  = 1'b1
    } src_e;

    typedef struct packed {
        src_e             src;
        rgb_t             direct;
        logic [IDX_W-1:0] idx;
    } pix_t;

    // Only the top byte of the control word selects the source.
    function automatic src_e classify(input logic [WORD_W-1:0] ctrl);
        return (ctrl[WORD_W-1 -: TAG_W] == TAG_DIRECT) ? SRC_DIRECT : SRC_PALETTE;
    endfunction

    // Red sits in bits 23:16, green in 15:8, blue in 7:0.
    function automatic rgb_t unpack_direct(input logic [WORD_W-1:0] w);
        rgb_t c;
        c.r = w[3*CHAN_W-1 -: CHAN_W];
        c.g = w[2*CHAN_W-1 -: CHAN_W];
        c.b = w[CHAN_W-1   -: CHAN_W];
        return c;
    endfunction

endpackage

// File: rtl/pix_tag_decode.sv
module pix_tag_decode
    import pix_sel_pkg::*;
(
    input  logic [IDX_W-1:0]  index_i,
    input  logic [WORD_W-1:0] direct_i,
    input  logic [WORD_W-1:0] ctrl_i,
    output pix_t              pix_o
);

    always_comb begin
        pix_o.src    = classify(ctrl_i);
        pix_o.direct = unpack_direct(direct_i);
        pix_o.idx    = index_i;
    end

endmodule

// File: rtl/pix_lookup_stage.sv
module pix_lookup_stage
    import pix_sel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  pix_t             in_pix,
    output logic             in_ready,
    output logic             pal_req,
    output logic [IDX_W-1:0] pal_addr,
    input  rgb_t             pal_rgb,
    output logic             s1_valid,
    output rgb_t             s1_rgb,
    input  logic             s1_take
);

    logic load;
    src_e src_q;
    rgb_t direct_q;
    rgb_t held_q;
    logic fresh_q;

    assign in_ready = !s1_valid || s1_take;
    assign load     = in_valid && in_ready;
    assign pal_req  = load && (in_pix.src == SRC_PALETTE);
    assign pal_addr = in_pix.idx;

    always_comb begin
        if (src_q == SRC_DIRECT)
            s1_rgb = direct_q;
        else if (fresh_q)
            s1_rgb = pal_rgb;
        else
            s1_rgb = held_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            fresh_q  <= 1'b0;
            src_q    <= SRC_PALETTE;
            direct_q <= '0;
            held_q   <= '0;
        end else begin
            if (fresh_q)
                held_q <= pal_rgb;
            if (load) begin
                s1_valid <= 1'b1;
                fresh_q  <= 1'b1;
                src_q    <= in_pix.src;
                direct_q <= in_pix.direct;
            end else begin
                fresh_q <= 1'b0;
                if (s1_take)
                    s1_valid <= 1'b0;
            end
        end
    end

    assert_pal_slot_R4: assert property (@(posedge clk) disable iff (rst)
        pal_req |=> (s1_valid && fresh_q && src_q == SRC_PALETTE));

    assert_capture_R9: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_take) |=> (s1_valid && $stable(s1_rgb)));

    assert_idle_nopal_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !pal_req);

endmodule

// File: rtl/pix_out_stage.sv
module pix_out_stage
    import pix_sel_pkg::*;
#(
    parameter int LINE_STRIDE = 1024
)(
    input  logic clk,
    input  logic rst,
    input  logic s1_valid,
    input  rgb_t s1_rgb,
    output logic s1_take,
    output logic out_valid,
    input  logic out_ready,
    output rgb_t out_rgb,
    output logic out_eol
);

    localparam int XW = (LINE_STRIDE > 1) ? $clog2(LINE_STRIDE) : 1;
    localparam logic [XW-1:0] X_LAST = XW'(LINE_STRIDE - 1);

    logic [XW-1:0] x_q;
    logic          fire;

    assign s1_take = !out_valid || out_ready;
    assign fire    = out_valid && out_ready;
    assign out_eol = out_valid && (x_q == X_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else if (s1_take) begin
            out_valid <= s1_valid;
            if (s1_valid)
                out_rgb <= s1_rgb;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            x_q <= '0;
        else if (fire)
            x_q <= (x_q == X_LAST) ? '0 : x_q + 1'b1;
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));

    assert_eol_once_R10: assert property (@(posedge clk) disable iff (rst)
        (fire && out_eol) |=> !out_eol);

    assert_take_R7: assert property (@(posedge clk) disable iff (rst)
        out_ready |-> s1_take);

endmodule

// File: rtl/pix_colour_sel.sv
module pix_colour_sel
    import pix_sel_pkg::*;
#(
    parameter int LINE_STRIDE = 1024
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IDX_W-1:0]  in_index,
    input  logic [WORD_W-1:0] in_direct,
    input  logic [WORD_W-1:0] in_ctrl,
    output logic              pal_req,
    output logic [IDX_W-1:0]  pal_addr,
    input  logic [RGB_W-1:0]  pal_rgb,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [RGB_W-1:0]  out_rgb,
    output logic              out_eol
);

    pix_t pix;
    logic s1_valid;
    rgb_t s1_rgb;
    logic s1_take;
    rgb_t out_c;

    pix_tag_decode u_decode (
        .index_i  (in_index),
        .direct_i (in_direct),
        .ctrl_i   (in_ctrl),
        .pix_o    (pix)
    );

    pix_lookup_stage u_lookup (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_pix   (pix),
        .in_ready (in_ready),
        .pal_req  (pal_req),
        .pal_addr (pal_addr),
        .pal_rgb  (rgb_t'(pal_rgb)),
        .s1_valid (s1_valid),
        .s1_rgb   (s1_rgb),
        .s1_take  (s1_take)
    );

    pix_out_stage #(.LINE_STRIDE(LINE_STRIDE)) u_out (
        .clk       (clk),
        .rst       (rst),
        .s1_valid  (s1_valid),
        .s1_rgb    (s1_rgb),
        .s1_take   (s1_take),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_rgb   (out_c),
        .out_eol   (out_eol)
    );

    assign out_rgb = out_c;

    assert_accept_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> s1_valid);

endmodule

// File: tb/pix_colour_sel_test.sv
module pix_colour_sel_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  in_index;
    logic [31:0] in_direct;
    logic [31:0] in_ctrl;
    logic        pal_req;
    logic [7:0]  pal_addr;
    logic [23:0] pal_rgb;
    logic        out_valid;
    logic        out_ready;
    logic [23:0] out_rgb;
    logic        out_eol;

    int checks = 0;
    int errors = 0;
    int in_cnt = 0;
    int out_cnt = 0;
    int eol_seen = 0;
    int cyc = 0;
    bit bp_on = 1'b0;
    bit done = 1'b0;
    bit prev_stall = 1'b0;
    logic [23:0] prev_rgb;
    logic [23:0] expq[$];

    always #4 clk = ~clk;

    pix_colour_sel uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_index(in_index), .in_direct(in_direct), .in_ctrl(in_ctrl),
        .pal_req(pal_req), .pal_addr(pal_addr), .pal_rgb(pal_rgb),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_rgb(out_rgb), .out_eol(out_eol)
    );

    function automatic logic [23:0] pal_fn(input logic [7:0] a);
        return {~a, a ^ 8'hA5, a + 8'd61};
    endfunction

    function automatic bit is_direct(input logic [31:0] c);
        return c[31:24] == 8'h03;
    endfunction

    function automatic logic [23:0] exp_fn(input logic [7:0] i, input logic [31:0] d,
                                           input logic [31:0] c);
        return is_direct(c) ? d[23:0] : pal_fn(i);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Palette model: correct data only in the cycle after a request (R4, R9).
    always @(posedge clk) begin
        pal_rgb <= pal_req ? pal_fn(pal_addr) : 24'($urandom);
    end

    always @(posedge clk) begin
        #1;
        out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (in_valid && in_ready) begin
                expq.push_back(exp_fn(in_index, in_direct, in_ctrl));
                in_cnt++;
                if (is_direct(in_ctrl))
                    check(pal_req == 1'b0, "R5 direct pixel pal_req", pal_req, 0);
                else
                    check(pal_req && pal_addr == in_index, "R4 palette request/addr",
                          {pal_req, pal_addr}, {1'b1, in_index});
            end else if (pal_req) begin
                check(1'b0, "R5 pal_req without accepted palette pixel", pal_req, 0);
            end
            if (in_valid && out_ready)
                check(in_ready, "R7 in_ready while out_ready", in_ready, 1);
            if (prev_stall)
                check(out_valid && out_rgb == prev_rgb, "R8 stall hold",
                      {out_valid, out_rgb}, {1'b1, prev_rgb});
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R6 output with nothing outstanding", out_rgb, 0);
                end else begin
                    logic [23:0] e;
                    e = expq.pop_front();
                    check(out_rgb == e, "R3/R4/R9 colour", out_rgb, e);
                end
                check(out_eol == ((out_cnt % 1024) == 1023), "R10 eol flag",
                      out_eol, ((out_cnt % 1024) == 1023));
                if (out_eol) eol_seen++;
                out_cnt++;
            end
            prev_stall = out_valid && !out_ready;
            prev_rgb   = out_rgb;
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R6 actual=%0d outputs expected=%0d", out_cnt, in_cnt);
            summary();
            $finish;
        end
    end

    task automatic send(input logic [7:0] i, input logic [31:0] d, input logic [31:0] c);
        bit acc;
        in_valid  = 1'b1;
        in_index  = i;
        in_direct = d;
        in_ctrl   = c;
        acc = 1'b0;
        while (!acc) begin
            @(negedge clk);
            acc = in_ready;
            if (!acc) begin
                @(posedge clk);
                #1;
            end
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] rand_ctrl();
        logic [7:0] tops[8] = '{8'h03, 8'h03, 8'h00, 8'h02, 8'h07, 8'h83, 8'h13, 8'hFF};
        return {tops[$urandom % 8], 24'($urandom)};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        in_valid = 1'b0;
        in_index = '0;
        in_direct = '0;
        in_ctrl = '0;
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !pal_req && in_ready, "R1 reset state",
              {out_valid, pal_req, in_ready}, 3'b001);
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !pal_req && in_ready, "R1 after reset",
              {out_valid, pal_req, in_ready}, 3'b001);
        @(posedge clk);
        #1;

        // R7 exact latency with a single direct pixel
        in_valid = 1'b1; in_index = 8'h44; in_direct = 32'hEE123456; in_ctrl = 32'h03000000;
        @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        @(negedge clk);
        check(!out_valid, "R7 not yet valid after first edge", out_valid, 0);
        @(negedge clk);
        check(out_valid && out_rgb == 24'h123456, "R7 valid after second edge, R3 order",
              {out_valid, out_rgb}, {1'b1, 24'h123456});
        @(posedge clk);
        #1;

        // Directed corner cases (R2, R3, R4)
        send(8'h00, 32'h11223344, 32'h03FFFFFF);
        send(8'hFF, 32'h00ABCDEF, 32'h13000000);
        send(8'h00, 32'hFF000000, 32'h02000000);
        send(8'h7E, 32'h00000000, 32'h03000000);
        send(8'hFF, 32'h00FFFFFF, 32'h03123456);
        send(8'h80, 32'h03FFFFFF, 32'h83000003);
        send(8'h01, 32'h55AA55AA, 32'h00000003);

        // Stall during palette return (R9)
        bp_on = 1'b1;
        for (int k = 0; k < 40; k++)
            send(8'(k * 7), 32'($urandom), (k % 2 == 0) ? 32'h01000000 : 32'h03000000);

        // Random traffic across several lines (R6, R8, R10)
        for (int n = 0; n < 2600; n++) begin
            if (n % 300 == 0) bp_on = ~bp_on;
            if (($urandom % 5) == 0) begin
                @(posedge clk);
                #1;
            end
            send(8'($urandom), 32'($urandom), rand_ctrl());
        end

        bp_on = 1'b0;
        while (expq.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
        check(in_cnt == out_cnt, "R6 beat count", out_cnt, in_cnt);
        check(eol_seen == out_cnt / 1024, "R10 number of line ends", eol_seen, out_cnt / 1024);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule